// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block drives several pulse-width-modulated pins from one register bus. Each channel has a 16-bit period counter that advances on the ticks of its own clock prescaler. The counter runs from zero up to the programmed period value, including that value, and then starts again. A two-edge compare window splits each period into two phases. While the count is inside the window, the pin takes the level of the channel's active-phase code. Outside the window, it takes the level of the inactive-phase code.

Software programs a channel by writing its window word first and its period word second. Both words go into shadow registers. The period write arms a transfer, and the running counter picks up both words only at its next wrap. An enabled output therefore never shows a partial mix of old and new settings. A disabled channel has no period in progress, so it takes an armed transfer on the next clock. One control word holds an enable bit for each channel and a self-clearing soft-reset bit. Three alias addresses set, clear or flip individual control bits without a read-modify-write.

Top module: `pwm_bank`

## Requirements
- R1: After the reset input, every pin is low and every register reads 0.
- R2: Bit n of the control word enables channel n. A write to offset 0x0 replaces the word. Offsets 0x4, 0x8 and 0xC set, clear or flip only the bits that are 1 in the data. All four offsets read back the control word.
- R3: Channel n's window word is at 0x10 + 0x20*n and its period word is at 0x20 + 0x20*n. Both read back as written. In the window word, bits [15:0] are the enter count and bits [31:16] are the leave count. In the period word, bits [15:0] are the period, [17:16] the active code, [19:18] the inactive code and [22:20] the prescaler select.
- R4: An enabled counter goes through 0..P and then wraps to 0, where P is the period. The channel is in its active phase when enter <= count < leave.
- R5: A level code of 3 drives the pin high. Codes 2, 1 and 0 drive it low. An inverted setting (active code 2, inactive code 3) gives the complement of the window.
- R6: Prescaler select values 0..7 advance the counter once every 1, 2, 4, 8, 16, 64, 256 or 1024 clocks.
- R7: A disabled channel drives its pin low and holds its counter at 0. When it is enabled again, it restarts from count 0.
- R8: A write to the window word alone has no effect on the output. A period write makes both shadow words take effect at the next wrap of a running counter, and not before.
- R9: Writing 1 to control bit 31 clears every register, counter and pin on the following clock. The bit reads back as 1 for exactly one cycle.
- R10: Channels keep separate counters, prescalers and settings and run without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM pin per channel |

## Verification
The waveform tests use a centred window on a ten-count period, so an off-by-one at either compare edge or at the wrap point changes a pin. Prescaler selects 2, 5 and 7 each pair a short period with a window that is high on only one count value. This makes the tick spacing visible, including the jump in the table after select 4. A mid-period reprogramming with inverted codes shows whether the new settings appear at the wrap or early. Two channels run at once with different dividers, and one of them is then stopped and restarted, which separates shared state from per-channel state.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

  // field positions inside the period word
  localparam int PER_LSB    = 0;
  localparam int ACODE_LSB  = 16;
  localparam int ICODE_LSB  = 18;
  localparam int DSEL_LSB   = 20;
  // field positions inside the window word
  localparam int ENTER_LSB  = 0;
  localparam int LEAVE_LSB  = 16;
  // control word
  localparam int SRST_BIT   = 31;
  // prescaler counter width covers the largest ratio (2^10)
  localparam int DIV_W      = 10;

  typedef struct packed {
    logic [15:0] enter_cnt;
    logic [15:0] leave_cnt;
    logic [15:0] period;
    logic [1:0]  act_code;
    logic [1:0]  idle_code;
    logic [2:0]  div_sel;
  } chan_cfg_t;

  // log2 of the division ratio for each select value
  function automatic logic [3:0] div_shift(input logic [2:0] sel);
    logic [3:0] s;
    case (sel)
      3'd5:    s = 4'd6;
      3'd6:    s = 4'd8;
      3'd7:    s = 4'd10;
      default: s = {1'b0, sel};
    endcase
    return s;
  endfunction

  // last prescaler count before a tick
  function automatic logic [DIV_W-1:0] div_limit(input logic [2:0] sel);
    return (DIV_W'(1) << div_shift(sel)) - DIV_W'(1);
  endfunction

  // only code 3 drives high
  function automatic logic code_level(input logic [1:0] code);
    return code == 2'b11;
  endfunction

  function automatic logic in_window(input logic [15:0] cnt,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (cnt >= lo) && (cnt < hi);
  endfunction

  function automatic chan_cfg_t unpack_cfg(input logic [31:0] win_w,
                                           input logic [31:0] per_w);
    chan_cfg_t c;
    c.enter_cnt = win_w[ENTER_LSB +: 16];
    c.leave_cnt = win_w[LEAVE_LSB +: 16];
    c.period    = per_w[PER_LSB   +: 16];
    c.act_code  = per_w[ACODE_LSB +: 2];
    c.idle_code = per_w[ICODE_LSB +: 2];
    c.div_sel   = per_w[DSEL_LSB  +: 3];
    return c;
  endfunction

endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  input  logic [NCH-1:0]        took_i,
  output logic [31:0]           rdata_o,
  output logic [NCH-1:0]        en_o,
  output logic                  srst_o,
  output logic [NCH-1:0]        pend_o,
  output logic [NCH-1:0][31:0]  win_sh_o,
  output logic [NCH-1:0][31:0]  per_sh_o
);
  import pwmx_pkg::*;

  localparam int WIN_BASE = 16;
  localparam int PER_BASE = 32;
  localparam int STRIDE   = 32;

  logic [NCH-1:0] en_q;
  logic           srst_q;
  logic           ctrl_hit;
  logic [NCH-1:0] win_hit, per_hit;

  assign ctrl_hit = (addr_i[ADDR_W-1:4] == '0);

  // control word with replace/set/clear/flip views; soft reset wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      srst_q <= 1'b0;
    end else if (srst_q) begin
      en_q   <= '0;
      srst_q <= 1'b0;
    end else if (wr_i && ctrl_hit) begin
      case (addr_i[3:2])
        2'd0: begin en_q <= wdata_i[NCH-1:0];          srst_q <= wdata_i[SRST_BIT]; end
        2'd1: begin en_q <= en_q | wdata_i[NCH-1:0];   srst_q <= wdata_i[SRST_BIT]; end
        2'd2: begin en_q <= en_q & ~wdata_i[NCH-1:0];  srst_q <= 1'b0;              end
        default: begin en_q <= en_q ^ wdata_i[NCH-1:0]; srst_q <= wdata_i[SRST_BIT]; end
      endcase
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_sh
    assign win_hit[i] = (addr_i == ADDR_W'(WIN_BASE + STRIDE * i));
    assign per_hit[i] = (addr_i == ADDR_W'(PER_BASE + STRIDE * i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_sh_o[i] <= '0;
        per_sh_o[i] <= '0;
        pend_o[i]   <= 1'b0;
      end else if (srst_q) begin
        win_sh_o[i] <= '0;
        per_sh_o[i] <= '0;
        pend_o[i]   <= 1'b0;
      end else begin
        if (wr_i && win_hit[i]) win_sh_o[i] <= wdata_i;
        if (wr_i && per_hit[i]) begin
          per_sh_o[i] <= wdata_i;
          pend_o[i]   <= 1'b1;
        end else if (took_i[i]) begin
          pend_o[i]   <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[NCH-1:0]  = en_q;
      rdata_o[SRST_BIT] = srst_q;
    end
    for (int i = 0; i < NCH; i++) begin
      if (win_hit[i]) rdata_o = win_sh_o[i];
      if (per_hit[i]) rdata_o = per_sh_o[i];
    end
  end

  assign en_o   = en_q;
  assign srst_o = srst_q;

  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q); // R9
  AST_SET_ALIAS_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ctrl_hit && addr_i[3:2] == 2'd1 && !srst_q)
      |=> ((en_q & $past(wdata_i[NCH-1:0])) == $past(wdata_i[NCH-1:0]))); // R2
  AST_CLR_ALIAS_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ctrl_hit && addr_i[3:2] == 2'd2)
      |=> ((en_q & $past(wdata_i[NCH-1:0])) == '0)); // R2

endmodule

// File: rtl/pwmx_prescale.sv
module pwmx_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  import pwmx_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim    = div_limit(sel_i);
  assign tick_o = run_i && (div_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  div_q <= '0;
    else if (clr_i || !run_i)    div_q <= '0;
    else if (tick_o)             div_q <= '0;
    else                         div_q <= div_q + DIV_W'(1);
  end

  AST_DIV1_TICKS_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && sel_i == 3'd0 && !$past(clr_i)) |-> tick_o); // R6

endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic                pend_i,
  input  pwmx_pkg::chan_cfg_t cfg_sh_i,
  input  logic                tick_i,
  output logic [2:0]          div_sel_o,
  output logic                took_o,
  output logic                bnd_o,
  output logic                pin_o
);
  import pwmx_pkg::*;

  chan_cfg_t   cfg_q;
  logic [15:0] cnt_q;
  logic        at_top;
  logic        active_ph;

  assign at_top    = (cnt_q == cfg_q.period);
  // a period boundary: wrap of a running counter, or any cycle while stopped
  assign bnd_o     = !en_i || (tick_i && at_top);
  assign took_o    = bnd_o && pend_i;
  assign div_sel_o = cfg_q.div_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (took_o) cfg_q <= cfg_sh_i;
      if (!en_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= at_top ? 16'd0 : cnt_q + 16'd1;
    end
  end

  assign active_ph = in_window(cnt_q, cfg_q.enter_cnt, cfg_q.leave_cnt);
  assign pin_o     = en_i && code_level(active_ph ? cfg_q.act_code : cfg_q.idle_code);

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cfg_q.period); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && at_top) |=> (cnt_q == 16'd0)); // R4
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == 16'd0)); // R7
  AST_CFG_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ($past(bnd_o) || $past(clr_i))); // R8

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  import pwmx_pkg::*;

  logic [NCH-1:0]       en, pend, took, tick, bnd;
  logic                 srst;
  logic [NCH-1:0][31:0] win_sh, per_sh;

  pwmx_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .took_i   (took),
    .rdata_o  (bus_rdata),
    .en_o     (en),
    .srst_o   (srst),
    .pend_o   (pend),
    .win_sh_o (win_sh),
    .per_sh_o (per_sh)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_cfg_t  cfg_sh;
    logic [2:0] dsel;

    assign cfg_sh = unpack_cfg(win_sh[i], per_sh[i]);

    pwmx_prescale u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (srst),
      .run_i  (en[i]),
      .sel_i  (dsel),
      .tick_o (tick[i])
    );

    pwmx_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (srst),
      .en_i      (en[i]),
      .pend_i    (pend[i]),
      .cfg_sh_i  (cfg_sh),
      .tick_i    (tick[i]),
      .div_sel_o (dsel),
      .took_o    (took[i]),
      .bnd_o     (bnd[i]),
      .pin_o     (pwm_out[i])
    );
  end

  AST_PIN_LOW_AFTER_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pwm_out == '0)); // R9

endmodule

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int n_chk = 0;
  int n_fail = 0;

  // scoreboard: one entry per sample, pins expected and which pins matter
  logic [1:0] q_exp[$];
  logic [1:0] q_msk[$];
  string      q_req[$];

  always #5 clk = ~clk;

  pwm_bank #(.NCH(2), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic push(input logic [1:0] e, input logic [1:0] m, input string r);
    q_exp.push_back(e); q_msk.push_back(m); q_req.push_back(r);
  endtask

  task automatic drain();
    while (q_exp.size() != 0) @(negedge clk);
  endtask

  function automatic bit win(input int c, input int lo, input int hi);
    return (c >= lo) && (c < hi);
  endfunction

  // monitor: one sample 3 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q_exp.size() != 0) begin
        logic [1:0] e, m;
        string r;
        e = q_exp.pop_front(); m = q_msk.pop_front(); r = q_req.pop_front();
        n_chk++;
        if ((pwm_out & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s: actual pins %b expected %b (mask %b)", r, pwm_out, e, m);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", {30'b0, pwm_out}, 32'h0);
    bus_read(8'h00, rd); check("R1", rd, 32'h0);
    bus_read(8'h10, rd); check("R1", rd, 32'h0);
    bus_read(8'h40, rd); check("R1", rd, 32'h0);

    // R2 control aliases
    bus_write(8'h04, 32'h1); bus_read(8'h00, rd); check("R2", rd, 32'h1);
    bus_write(8'h04, 32'h2); bus_read(8'h04, rd); check("R2", rd, 32'h3);
    bus_write(8'h08, 32'h1); bus_read(8'h08, rd); check("R2", rd, 32'h2);
    bus_write(8'h0C, 32'h3); bus_read(8'h0C, rd); check("R2", rd, 32'h1);
    bus_write(8'h00, 32'h2); bus_read(8'h00, rd); check("R2", rd, 32'h2);
    bus_write(8'h08, 32'h3); bus_read(8'h00, rd); check("R2", rd, 32'h0);

    // R3 register map and readback
    bus_write(8'h30, 32'h0005_0002);
    bus_write(8'h40, 32'h0031_0009);
    bus_read(8'h30, rd); check("R3", rd, 32'h0005_0002);
    bus_read(8'h40, rd); check("R3", rd, 32'h0031_0009);
    bus_read(8'h10, rd); check("R3", rd, 32'h0);
    bus_read(8'h20, rd); check("R3", rd, 32'h0);

    // R4 window [2,6) over period 9, normal codes, divide by 1
    bus_write(8'h10, (32'd6 << 16) | 32'd2);
    bus_write(8'h20, 32'd9 | (32'd3 << 16) | (32'd2 << 18));
    bus_write(8'h04, 32'h1);
    for (int j = 1; j <= 25; j++) push({1'b0, win(j % 10, 2, 6)}, 2'b01, "R4");
    drain();

    // R8 / R5: window-only write then period write mid-period
    bus_write(8'h08, 32'h1);
    bus_write(8'h04, 32'h1);
    for (int j = 1; j <= 30; j++) begin
      if (j < 10) push({1'b0, win(j, 2, 6)}, 2'b01, "R8");
      else        push({1'b0, !win((j - 10) % 5, 0, 3)}, 2'b01, (j <= 11) ? "R8" : "R5");
    end
    bus_write(8'h10, (32'd3 << 16) | 32'd0);
    bus_write(8'h20, 32'd4 | (32'd2 << 16) | (32'd3 << 18));
    drain();

    // R6 prescaler select 2 (divide by 4)
    bus_write(8'h08, 32'h1);
    bus_write(8'h10, (32'd2 << 16) | 32'd1);
    bus_write(8'h20, 32'd2 | (32'd3 << 16) | (32'd2 << 18) | (32'd2 << 20));
    bus_write(8'h04, 32'h1);
    for (int j = 1; j <= 40; j++) push({1'b0, ((j / 4) % 3) == 1}, 2'b01, "R6");
    drain();

    // R6 prescaler select 5 (divide by 64)
    bus_write(8'h08, 32'h1);
    bus_write(8'h10, (32'd1 << 16) | 32'd0);
    bus_write(8'h20, 32'd1 | (32'd3 << 16) | (32'd2 << 18) | (32'd5 << 20));
    bus_write(8'h04, 32'h1);
    for (int j = 1; j <= 260; j++) push({1'b0, ((j / 64) % 2) == 0}, 2'b01, "R6");
    drain();

    // R6 prescaler select 7 (divide by 1024)
    bus_write(8'h08, 32'h1);
    bus_write(8'h10, (32'd2 << 16) | 32'd1);
    bus_write(8'h20, 32'd1 | (32'd3 << 16) | (32'd2 << 18) | (32'd7 << 20));
    bus_write(8'h04, 32'h1);
    for (int j = 1; j <= 2100; j++) push({1'b0, ((j / 1024) % 2) == 1}, 2'b01, "R6");
    drain();

    // R7: both disabled, configured, pins stay low
    bus_write(8'h08, 32'h3);
    bus_write(8'h30, (32'd5 << 16) | 32'd0);
    bus_write(8'h40, 32'd9 | (32'd3 << 16) | (32'd2 << 18));
    bus_write(8'h10, (32'd2 << 16) | 32'd1);
    bus_write(8'h20, 32'd3 | (32'd3 << 16) | (32'd2 << 18) | (32'd1 << 20));
    for (int j = 1; j <= 8; j++) push(2'b00, 2'b11, "R7");
    drain();

    // R10: both channels together
    bus_write(8'h04, 32'h3);
    for (int j = 1; j <= 40; j++)
      push({win(j % 10, 0, 5), win((j / 2) % 4, 1, 2)}, 2'b11, "R10");
    drain();

    // R7: stop channel 1, then restart from count 0
    bus_write(8'h08, 32'h2);
    for (int j = 1; j <= 10; j++) push(2'b00, 2'b10, "R7");
    drain();
    bus_write(8'h04, 32'h2);
    for (int j = 1; j <= 20; j++) push({win(j % 10, 0, 5), 1'b0}, 2'b10, "R7");
    drain();

    // R9 soft reset
    bus_write(8'h04, 32'h8000_0000);
    bus_read(8'h00, rd); check("R9", rd, 32'h8000_0003);
    @(negedge clk);
    bus_read(8'h00, rd); check("R9", rd, 32'h0);
    bus_read(8'h30, rd); check("R9", rd, 32'h0);
    bus_read(8'h40, rd); check("R9", rd, 32'h0);
    check("R9", {30'b0, pwm_out}, 32'h0);
    repeat (5) @(negedge clk);
    check("R9", {30'b0, pwm_out}, 32'h0);

    finish_up();
  end

endmodule